// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Logic

This block generates the system reset for a board or chip that runs from three monitored supplies. External comparators decide whether each supply is above its threshold and hand over one "rail good" flag per supply. The block also takes an active-low manual-reset request, for example from a push button or from other logic. It drives a reset in both polarities.

Each rail flag passes through a two-flop synchronizer and then a per-rail persistence filter. The filter ignores any excursion shorter than `GLITCH_CYCLES` clock cycles. The manual-reset request is only synchronized and is not filtered, so a very short pulse still takes effect.

Reset asserts quickly whenever any source reports a fault. Reset is released only after every source has stayed clear for `TIMEOUT_CYCLES` consecutive cycles. Any new fault during that wait restarts the count.

The timing figures below use these names:
- G is `GLITCH_CYCLES`.
- T is `TIMEOUT_CYCLES`.
- Edges are counted from the first rising clock edge after an input change.

Top module: `rail_reset_supervisor`

## Requirements
- R1: While any filtered rail flag is low, reset is asserted. Release requires all three rail flags high and `man_rst_n_i` high; this is an AND over the four sources.
- R2: Reset releases on edge 2+G+T after the last rail flag rises, or on edge 2+T after the manual request rises, given no other fault. It is still asserted one edge earlier.
- R3: If a rail flag falls after release, reset re-asserts on edge 3+G with no timeout. It is still released on edge 2+G.
- R4: A low level on `man_rst_n_i` asserts reset on edge 3, whatever the rail flags are. A low level lasting one clock cycle is enough.
- R5: After `man_rst_n_i` returns high, reset stays asserted for the full timeout, with release timed as in R2.
- R6: `rst_o` and `rst_n_o` are always complementary: `rst_o` is 1 when reset is asserted.
- R7: A rail-flag excursion lasting G-1 cycles has no effect on the outputs. An excursion lasting G cycles is accepted.
- R8: While `arst_n` is low, reset is asserted. After `arst_n` releases with all sources good, the first release comes on edge 2+G+T.
- R9: A fault that occurs during the timeout restarts the full timeout from the moment that fault clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| rail_ok_i | input | RAILS | Per-rail good flags from the comparators, asynchronous |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
The hardest situation to reach is a fault that starts and ends while the timeout is already counting. The outputs do not change at all when it happens; its only visible effect is that the release comes later.

The bench starts a timeout by raising the manual request, then drops the request for one cycle halfway through the count. It checks that the release lands exactly T cycles (plus the synchronizer delay) after the second rise, and not after the first.

Glitch rejection is checked the same way. The bench applies a rail excursion exactly one cycle shorter than the filter length and watches the outputs over the whole window. It then applies an excursion of exactly the filter length and expects reset to assert.

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor #(
  parameter int RAILS          = 3,
  parameter int GLITCH_CYCLES  = 300,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [RAILS-1:0] rail_ok_i,
  input  logic             man_rst_n_i,
  output logic             rst_o,
  output logic             rst_n_o
);
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [RAILS-1:0] rail_s1, rail_s2, rail_good;
  logic             man_s1, man_s2;
  logic             fault, rst_q;
  logic [TW-1:0]    tcnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rail_s1 <= '0;
      rail_s2 <= '0;
      man_s1  <= 1'b0;
      man_s2  <= 1'b0;
    end else begin
      rail_s1 <= rail_ok_i;
      rail_s2 <= rail_s1;
      man_s1  <= man_rst_n_i;
      man_s2  <= man_s1;
    end
  end

  for (genvar i = 0; i < RAILS; i++) begin : g_filt
    logic [GW-1:0] cnt;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        cnt          <= '0;
        rail_good[i] <= 1'b0;
      end else if (rail_s2[i] == rail_good[i]) begin
        cnt <= '0;
      end else if (cnt == GW'(GLITCH_CYCLES - 1)) begin
        cnt          <= '0;
        rail_good[i] <= rail_s2[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign fault = !(&rail_good) || !man_s2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tcnt  <= '0;
      rst_q <= 1'b1;
    end else if (fault) begin
      tcnt  <= '0;
      rst_q <= 1'b1;
    end else if (rst_q) begin
      if (tcnt == TW'(TIMEOUT_CYCLES - 1)) rst_q <= 1'b0;
      else                                 tcnt  <= tcnt + 1'b1;
    end
  end

  assign rst_o   = rst_q;
  assign rst_n_o = ~rst_q;
endmodule

// File: rtl/rail_reset_supervisor_chk.sv
module rail_reset_supervisor_chk #(
  parameter int RAILS          = 3,
  parameter int TIMEOUT_CYCLES = 10_000_000
) (
  input logic             clk,
  input logic             arst_n,
  input logic [RAILS-1:0] rail_good,
  input logic             man_s2,
  input logic             rst_o,
  input logic             rst_n_o
);
  localparam int QW = $clog2(TIMEOUT_CYCLES + 1) + 1;

  logic [QW-1:0] quiet;
  logic          src_fault;

  assign src_fault = !(&rail_good) || !man_s2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                          quiet <= '0;
    else if (src_fault)                   quiet <= '0;
    else if (quiet < QW'(TIMEOUT_CYCLES)) quiet <= quiet + 1'b1;
  end

  p_complement_r6: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o != rst_n_o);

  p_rail_fault_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !(&rail_good) |=> rst_o);

  p_manual_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !man_s2 |=> rst_o);

  // R2 and R9: no release before a full quiet window
  p_full_timeout_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> quiet >= QW'(TIMEOUT_CYCLES));

  p_release_clean_r9: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> $past(!src_fault));
endmodule

bind rail_reset_supervisor rail_reset_supervisor_chk #(
  .RAILS(RAILS), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk(clk), .arst_n(arst_n), .rail_good(rail_good), .man_s2(man_s2),
  .rst_o(rst_o), .rst_n_o(rst_n_o)
);

// File: tb/rail_reset_supervisor_bench.sv
module rail_reset_supervisor_bench;
  localparam int G = 8;
  localparam int T = 40;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [2:0] rails = 3'b111;
  logic       man_n = 1'b1;
  logic       rst_o, rst_n_o;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  // {man_n, rails[2:0], expected rst_o}
  localparam logic [4:0] VEC [16] = '{
    5'b0_000_1, 5'b0_001_1, 5'b0_010_1, 5'b0_011_1,
    5'b0_100_1, 5'b0_101_1, 5'b0_110_1, 5'b0_111_1,
    5'b1_000_1, 5'b1_001_1, 5'b1_010_1, 5'b1_011_1,
    5'b1_100_1, 5'b1_101_1, 5'b1_110_1, 5'b1_111_0
  };

  always #10 clk = ~clk;

  rail_reset_supervisor #(.RAILS(3), .GLITCH_CYCLES(G), .TIMEOUT_CYCLES(T)) u_rail_reset_supervisor (
    .clk(clk), .arst_n(arst_n), .rail_ok_i(rails), .man_rst_n_i(man_n),
    .rst_o(rst_o), .rst_n_o(rst_n_o)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic exp);
    checks++;
    if (rst_o !== exp || rst_n_o !== ~exp) begin
      fails++;
      $display("FAIL %s: rst_o=%b rst_n_o=%b expected rst_o=%b rst_n_o=%b",
               tag, rst_o, rst_n_o, exp, ~exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: expected=finished actual=hung");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    cyc(3);
    chk("R8 asserted during arst", 1'b1);
    arst_n = 1'b1;
    cyc(2 + G + T - 1);
    chk("R8 first release not early", 1'b1);
    cyc(1);
    chk("R8 first release on time", 1'b0);

    for (int i = 0; i < 16; i++) begin
      {man_n, rails} = VEC[i][4:1];
      cyc(G + 4);
      chk($sformatf("R1/R4 truth vector %0d", i), VEC[i][0]);
      man_n = 1'b1;
      rails = 3'b111;
      cyc(G + T + 4);
    end

    man_n = 1'b0;
    cyc(5);
    man_n = 1'b1;
    cyc(2 + T - 1);
    chk("R5 held after manual rise", 1'b1);
    cyc(1);
    chk("R2 manual timeout length", 1'b0);

    rails = 3'b101;
    cyc(G + 4);
    chk("R1 one rail low", 1'b1);
    rails = 3'b111;
    cyc(2 + G + T - 1);
    chk("R2 rail timeout not early", 1'b1);
    cyc(1);
    chk("R2 rail timeout length", 1'b0);

    rails = 3'b011;
    cyc(2 + G);
    chk("R3 not before filter", 1'b0);
    cyc(1);
    chk("R3 fast re-assert", 1'b1);
    rails = 3'b111;
    cyc(2 + G + T + 2);
    chk("R3 recovers", 1'b0);

    man_n = 1'b0;
    cyc(1);
    man_n = 1'b1;
    cyc(2);
    chk("R4 one-cycle manual pulse", 1'b1);
    cyc(T - 1);
    chk("R4 held after short pulse", 1'b1);
    cyc(1);
    chk("R4 release after short pulse", 1'b0);

    man_n = 1'b0;
    cyc(3);
    man_n = 1'b1;
    cyc(T / 2);
    man_n = 1'b0;
    cyc(1);
    man_n = 1'b1;
    cyc(2 + T - 1);
    chk("R9 timeout restarted", 1'b1);
    cyc(1);
    chk("R9 release after restart", 1'b0);

    rails = 3'b110;
    cyc(G - 1);
    rails = 3'b111;
    bad = 0;
    for (int k = 0; k < 25; k++) begin
      if (rst_o !== 1'b0 || rst_n_o !== 1'b1) bad++;
      cyc(1);
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R7 short glitch: cycles_asserted=%0d expected=0", bad);
    end

    rails = 3'b110;
    cyc(G);
    rails = 3'b111;
    cyc(2);
    chk("R7 full-width excursion pending", 1'b0);
    cyc(1);
    chk("R7 full-width excursion accepted", 1'b1);
    cyc(2 * G + T + 5);
    chk("R7 recovers", 1'b0);

    arst_n = 1'b0;
    cyc(1);
    chk("R8 asynchronous reset re-asserts", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule